// File: doc/BRIEF.md
# Bitstream Line Encoder

The encoder turns a serial bit stream, presented one bit at a time by an external byte-wide shift register, into a line-coded output. Three formats are available: plain NRZ, where the line follows the data; Manchester, where every bit carries a mid-bit transition; and biphase, where every bit boundary carries a transition and a zero adds a second one mid-bit. The bit rate comes from an external half-bit tick that pulses once for each half of a bit period. The encoder samples the data bit on the tick that opens a bit, so the shift register may advance between those ticks.

The shift register only delivers whole bytes. The encoder counts bit positions within each byte, so a frame can end inside its final byte. The shift register raises a final-byte flag while it presents the last byte. The encoder then stops after a programmed number of bits of that byte, pulses done and returns the line to its idle level. A frame therefore needs no padding to a multiple of eight bits.

Top module: `bitstream_line_encoder`

## Requirements
- R1: After reset, line_out is 0 and busy and done are 0.
- R2: With mode 0, and also with mode 3, the line carries the data bit unchanged for both halves of the bit period.
- R3: With mode 1 (Manchester), a 1 is sent as high in the first half and low in the second half, and a 0 is sent as low then high.
- R4: With mode 2 (biphase), the line inverts at the start of every bit. It inverts again at mid-bit only for a 0. The first bit inverts relative to the idle level.
- R5: A start while idle sets busy in the next cycle. The first half-bit tick after that opens bit 0, and the following tick moves to its second half. The line changes only on the cycle after a tick, and only while busy.
- R6: The final_count is sampled at start. The frame ends after that many bits of the byte that began with final_byte high. A value of 0 or above 8 counts as 8.
- R7: The tick that closes the last bit causes done to be high for exactly one cycle in the next cycle. In that same cycle busy is low and line_out is at the idle level.
- R8: A start while busy is ignored, including one in the same cycle as the tick that closes the last bit. Mode and final_count changes after start do not affect the running frame.
- R9: While not busy, line_out follows idle_level with one cycle of delay, and half-bit ticks have no effect.
- R10: A byte that did not begin with final_byte high is always sent as all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Current serial data bit from the shift register |
| final_byte | input | 1 | High while the shift register presents the last byte of the frame |
| half_tick | input | 1 | One-cycle pulse per half bit period |
| mode | input | 2 | 0/3 NRZ, 1 Manchester, 2 biphase; sampled at start |
| idle_level | input | 1 | Line level while no frame is running |
| start | input | 1 | Begin a frame (ignored while busy) |
| final_count | input | 4 | Number of bits to send from the final byte, 1..8 |
| line_out | output | 1 | Encoded line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the last bit ends |

## Verification
Two events can arrive in the same cycle: a new start request and the tick that closes the final bit, which ends the frame. The bench raises start together with that closing tick on selected frames. It then expects busy low, a single done pulse and the idle line. A further tick must leave the line idle, which confirms that no second frame was launched. The sweep covers every mode, both idle levels, every final-byte length and one- and two-byte frames. Each half-bit level is predicted from the encoding rules.

// File: rtl/linecode_pkg.sv
package linecode_pkg;

    typedef enum logic [1:0] {
        LC_NRZ     = 2'd0,
        LC_MANCH   = 2'd1,
        LC_BIPHASE = 2'd2,
        LC_NRZ_ALT = 2'd3
    } lc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FIRST  = 2'd2,
        ST_SECOND = 2'd3
    } lc_state_e;

    typedef struct packed {
        lc_state_e st;
        lc_mode_e  mode;
        logic      line;
        logic      sec;
        logic      done;
    } enc_regs_t;

endpackage

// File: rtl/lc_shaper.sv
module lc_shaper
    import linecode_pkg::*;
(
    input  lc_mode_e mode,
    input  logic     bit_val,
    input  logic     prev_level,
    output logic     lvl_first,
    output logic     lvl_second
);

    always_comb begin
        unique case (mode)
            LC_MANCH: begin
                lvl_first  = bit_val;
                lvl_second = ~bit_val;
            end
            LC_BIPHASE: begin
                lvl_first  = ~prev_level;
                lvl_second = bit_val ? ~prev_level : prev_level;
            end
            default: begin
                lvl_first  = bit_val;
                lvl_second = bit_val;
            end
        endcase
    end

endmodule

// File: rtl/lc_bit_tracker.sv
module lc_bit_tracker #(
    parameter int BYTE_BITS = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count_in,
    input  logic             bit_begin,
    input  logic             bit_end,
    input  logic             final_byte,
    output logic             final_bit
);

    localparam int POS_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(BYTE_BITS);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic             last;
    } trk_regs_t;

    trk_regs_t r_q, r_d;
    logic [POS_W-1:0] pos_next;

    always_comb begin
        r_d      = r_q;
        pos_next = r_q.pos;
        if (bit_end) begin
            pos_next = (r_q.pos == POS_LAST) ? '0 : r_q.pos + 1'b1;
        end
        if (load) begin
            r_d.pos  = '0;
            r_d.last = 1'b0;
            r_d.cnt  = (count_in == '0 || count_in > CNT_FULL) ? CNT_FULL : count_in;
        end else begin
            r_d.pos = pos_next;
            if (bit_begin && pos_next == '0) begin
                r_d.last = final_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{pos: '0, cnt: CNT_FULL, last: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign final_bit = r_q.last && ((CNT_W'(r_q.pos) + 1'b1) == r_q.cnt);

endmodule

// File: rtl/bitstream_line_encoder.sv
module bitstream_line_encoder
    import linecode_pkg::*;
#(
    parameter int BYTE_BITS = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_in,
    input  logic             final_byte,
    input  logic             half_tick,
    input  logic [1:0]       mode,
    input  logic             idle_level,
    input  logic             start,
    input  logic [CNT_W-1:0] final_count,
    output logic             line_out,
    output logic             busy,
    output logic             done
);

    enc_regs_t r_q, r_d;
    logic      lvl_first, lvl_second;
    logic      final_bit;
    logic      load, bit_begin, bit_end;

    lc_shaper u_shaper (
        .mode       (r_q.mode),
        .bit_val    (data_in),
        .prev_level (r_q.line),
        .lvl_first  (lvl_first),
        .lvl_second (lvl_second)
    );

    lc_bit_tracker #(
        .BYTE_BITS (BYTE_BITS),
        .CNT_W     (CNT_W)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .count_in   (final_count),
        .bit_begin  (bit_begin),
        .bit_end    (bit_end),
        .final_byte (final_byte),
        .final_bit  (final_bit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        load      = 1'b0;
        bit_begin = 1'b0;
        bit_end   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.line = idle_level;
                if (start) begin
                    load     = 1'b1;
                    r_d.st   = ST_ARMED;
                    r_d.mode = lc_mode_e'(mode);
                end
            end
            ST_ARMED: begin
                if (half_tick) begin
                    bit_begin = 1'b1;
                    r_d.line  = lvl_first;
                    r_d.sec   = lvl_second;
                    r_d.st    = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (half_tick) begin
                    r_d.line = r_q.sec;
                    r_d.st   = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (half_tick) begin
                    bit_end = 1'b1;
                    if (final_bit) begin
                        r_d.st   = ST_IDLE;
                        r_d.line = idle_level;
                        r_d.done = 1'b1;
                    end else begin
                        bit_begin = 1'b1;
                        r_d.line  = lvl_first;
                        r_d.sec   = lvl_second;
                        r_d.st    = ST_FIRST;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: LC_NRZ, line: 1'b0, sec: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign line_out = r_q.line;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;

endmodule

// File: rtl/lc_encoder_checker.sv
module lc_encoder_checker (
    input logic clk,
    input logic rst_n,
    input logic half_tick,
    input logic start,
    input logic idle_level,
    input logic line_out,
    input logic busy,
    input logic done
);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && line_out == $past(idle_level)));

    a_r7_done_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(half_tick));

    a_r5_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !half_tick) |=> $stable(line_out));

    a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !half_tick) |=> busy);

    a_r9_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (line_out == $past(idle_level)));

endmodule

bind bitstream_line_encoder lc_encoder_checker u_lc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .start      (start),
    .idle_level (idle_level),
    .line_out   (line_out),
    .busy       (busy),
    .done       (done)
);

// File: tb/bitstream_line_encoder_test.sv
module bitstream_line_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_in = 1'b0;
    logic       final_byte = 1'b0;
    logic       half_tick = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       idle_level = 1'b0;
    logic       start = 1'b0;
    logic [3:0] final_count = 4'd8;
    logic       line_out, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bitstream_line_encoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_in     (data_in),
        .final_byte  (final_byte),
        .half_tick   (half_tick),
        .mode        (mode),
        .idle_level  (idle_level),
        .start       (start),
        .final_count (final_count),
        .line_out    (line_out),
        .busy        (busy),
        .done        (done)
    );

    task automatic check(input string req, input logic actual, input logic expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One tick cycle; optional start in the same cycle. Leaves at the negedge after.
    task automatic do_tick(input logic with_start);
        half_tick = 1'b1;
        start     = with_start;
        if (with_start) mode = 2'd1;
        @(negedge clk);
        half_tick = 1'b0;
        start     = 1'b0;
    endtask

    task automatic run_frame(input int md, input logic idl, input int nbytes,
                             input int cnt, input int seed,
                             input bit end_start, input bit mid_start);
        int   eff;
        int   total;
        logic prev;
        logic f, s, d;
        string rq;
        eff   = (cnt == 0 || cnt > 8) ? 8 : cnt;
        total = (nbytes - 1) * 8 + eff;
        rq    = (md == 1) ? "R3" : (md == 2) ? "R4" : "R2";
        idle_level = idl;
        @(negedge clk);
        @(negedge clk);
        check("R9", line_out, idl);
        // start
        mode        = md[1:0];
        final_count = cnt[3:0];
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
        check("R5", busy, 1'b1);
        check("R5", line_out, idl);
        // change latched inputs (R8: no effect on running frame)
        mode        = md[1:0] ^ 2'd1;
        final_count = 4'd3;
        prev = idl;
        for (int i = 0; i < total; i++) begin
            d          = ((seed * 13 + i * i + i * 5) >> 1) & 1;
            data_in    = d;
            final_byte = ((i / 8) == nbytes - 1);
            if (md == 1) begin
                f = d; s = ~d;
            end else if (md == 2) begin
                f = ~prev; s = d ? f : ~f;
            end else begin
                f = d; s = d;
            end
            do_tick(1'b0);
            check(rq, line_out, f);
            if (mid_start && i == 1) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R8", busy, 1'b1);
            end else begin
                @(negedge clk);
            end
            data_in = ~d;
            do_tick(1'b0);
            check(rq, line_out, s);
            @(negedge clk);
            prev = s;
            if (i == 7 && nbytes == 2) check("R10", busy, 1'b1);
            if (i < total - 1) begin
                check("R6", busy, 1'b1);
            end
        end
        // closing tick of the last bit
        do_tick(end_start);
        check("R7", done, 1'b1);
        check("R7", busy, 1'b0);
        check("R7", line_out, idl);
        if (eff < 8 || nbytes > 1) check("R6", busy, 1'b0);
        @(negedge clk);
        check("R7", done, 1'b0);
        if (end_start) begin
            check("R8", busy, 1'b0);
            do_tick(1'b0);
            check("R8", line_out, idl);
            check("R8", busy, 1'b0);
        end
        final_byte = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", line_out, 1'b0);
        check("R1", busy, 1'b0);
        check("R1", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", line_out, 1'b0);
        // R9: ticks while idle have no effect; line follows idle level
        idle_level = 1'b1;
        @(negedge clk);
        check("R9", line_out, 1'b1);
        for (int k = 0; k < 4; k++) begin
            do_tick(1'b0);
            check("R9", line_out, 1'b1);
            check("R9", busy, 1'b0);
        end
        // sweep: mode x idle x final count x byte count
        for (int md = 0; md < 4; md++)
            for (int idl = 0; idl < 2; idl++)
                for (int cnt = 1; cnt <= 8; cnt++)
                    for (int nb = 1; nb <= 2; nb++)
                        run_frame(md, idl[0], nb, cnt, md * 31 + cnt * 7 + nb,
                                  (cnt % 3) == 0, (cnt == 5));
        // R6 out-of-range counts are treated as 8
        run_frame(1, 1'b0, 1, 0, 3, 1'b0, 1'b0);
        run_frame(2, 1'b1, 1, 12, 9, 1'b1, 1'b0);
        run_frame(2, 1'b0, 2, 15, 4, 1'b0, 1'b1);
        finish_run();
    end

endmodule